// File: doc/BRIEF.md
# Edge-Interval Serial Character Decoder

This block recovers 8N1 asynchronous serial characters by measuring the time between transitions on the receive line. It does not sample each bit in its centre. The line first passes through a two-stage synchroniser. A falling edge seen while the decoder is idle opens a character and starts an interval counter. Every later transition, rising or falling, closes the run that just ended and records its length. That length is rounded to a whole number of bit periods and expanded into that many copies of the level the line held during the run. The recovered bits are placed least significant bit first.

The run lengths are summed into the time elapsed since the start edge. When the elapsed time reaches the middle of the stop bit, the character is closed. A trailing run that has no closing edge, such as a high tail that runs into the stop bit, is completed from the current line level. The byte is then presented with a one-cycle strobe, together with a framing-error flag when the stop bit decodes low or too many bits were recovered. The bit period is a parameter in clock cycles.

Top module: `uart_ei_rx`

## Requirements
- R1: After reset `valid_o` and `frame_err_o` are low and `data_o` is zero. The line is sampled through two register stages, and its idle level is high.
- R2: A frame begins only on a high-to-low transition of the synchronised line while idle. A line that stays high, or a rising transition while idle, produces no output.
- R3: Each transition inside a frame closes a run of W cycles, which decodes to floor((W + BIT_W/2) / BIT_W) bits at the level held during that run. Moving a single transition by up to BIT_W/2-1 cycles does not change the decoded byte.
- R4: Bits are collected in arrival order. Frame position 0 is the start bit, positions 1 to 8 are data bits 0 to 7, and position 9 is the stop bit. So the first bit after the start bit appears in `data_o[0]`.
- R5: A frame completes when the elapsed time since the start edge reaches (DATA_BITS+1)*BIT_W + BIT_W/2 cycles. Positions not yet filled by closed runs take the level of the run still open at that moment.
- R6: `valid_o` is a one-cycle pulse per completed frame. `data_o` keeps the last byte until the next completion.
- R7: `frame_err_o` pulses together with `valid_o` when frame position 9 (the stop bit) decodes as 0.
- R8: `frame_err_o` pulses together with `valid_o` when the closed runs of a frame sum to more than 10 bits. Bits beyond position 9 are dropped.
- R9: A transition that falls on the completion cycle is counted into the frame that is ending. If that transition is falling, it also opens the next frame, so two characters separated by a half-length stop bit both decode.
- R10: After a frame that ends with the line low, no new frame opens until the line has gone high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| data_o | output | DATA_BITS | Last decoded byte |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| frame_err_o | output | 1 | Framing error, valid with `valid_o` |

## Verification
A transition and the completion threshold can land in the same cycle. In that cycle the decoder must both count the closing run into the frame that is ending and, when the transition is falling, open the next frame. The bench provokes this by sending 0xFF with a stop bit only half a period long and following it at once with a second character. That places the next start edge exactly on the completion cycle. The case passes only if exactly two strobes appear, carrying 0xFF and then 0x5A, with no framing error.

// File: rtl/uart_ei_pkg.sv
package uart_ei_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // whole bit periods in a run, rounded to nearest
  function automatic int unsigned run_len(input int unsigned width, input int unsigned bit_w);
    return (width + bit_w / 2) / bit_w;
  endfunction

endpackage

// File: rtl/uart_ei_sync.sv
module uart_ei_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic lvl_o,
  output logic edge_o,
  output logic fall_o
);

  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = lvl_q ^ prev_q;
  assign fall_o = prev_q & ~lvl_q;

endmodule

// File: rtl/uart_ei_timer.sv
module uart_ei_timer #(
  parameter int unsigned STOP_PT = 152,
  parameter int unsigned CW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          fall_i,
  output logic          busy_o,
  output logic          cap_o,
  output logic          done_o,
  output logic          start_o,
  output logic [CW-1:0] width_o
);

  import uart_ei_pkg::*;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q, sum_q;
  logic [CW:0]   elapsed;

  assign elapsed = {1'b0, sum_q} + {1'b0, cnt_q};
  assign busy_o  = (state_q == RX_BUSY);
  assign done_o  = busy_o && (elapsed >= (CW+1)'(STOP_PT));
  assign cap_o   = busy_o && edge_i;
  // a falling edge on the completion cycle re-arms at once
  assign start_o = fall_i && (!busy_o || done_o);
  assign width_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sum_q   <= '0;
    end else if (start_o) begin
      state_q <= RX_BUSY;
      cnt_q   <= CW'(1);
      sum_q   <= '0;
    end else if (done_o) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sum_q   <= '0;
    end else if (busy_o) begin
      if (edge_i) begin
        sum_q <= sum_q + cnt_q;
        cnt_q <= CW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R5
  elapsed_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> elapsed <= (CW+1)'(STOP_PT));

  // R2
  start_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fall_i));

endmodule

// File: rtl/uart_ei_assemble.sv
module uart_ei_assemble #(
  parameter int unsigned BIT_W     = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned FRAME_W   = 10,
  parameter int unsigned NB_W      = 5,
  parameter int unsigned CW        = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_i,
  input  logic                 start_i,
  input  logic                 done_i,
  input  logic [CW-1:0]        width_i,
  input  logic                 lvl_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);

  logic [FRAME_W-1:0]   frame_q, frame_nx;
  logic [NB_W-1:0]      nbits_q, n_run, tot;
  logic                 ovf_q, ovf_nx;
  logic [DATA_BITS-1:0] data_q;
  logic                 valid_q, err_q;

  always_comb begin
    n_run    = cap_i ? NB_W'(uart_ei_pkg::run_len(32'(width_i), BIT_W)) : '0;
    tot      = nbits_q + n_run;
    ovf_nx   = ovf_q | (tot > NB_W'(FRAME_W));
    frame_nx = frame_q;
    for (int i = 0; i < FRAME_W; i++) begin
      // closed run carries the level before the edge
      if (NB_W'(i) >= nbits_q && NB_W'(i) < tot) frame_nx[i] = ~lvl_i;
      // open run fills what is left
      if (done_i && NB_W'(i) >= tot) frame_nx[i] = lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      nbits_q <= '0;
      ovf_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= done_i;
      err_q   <= done_i && (ovf_nx || !frame_nx[FRAME_W-1]);
      if (done_i) data_q <= frame_nx[DATA_BITS:1];
      if (start_i || done_i) begin
        frame_q <= '0;
        nbits_q <= '0;
        ovf_q   <= 1'b0;
      end else if (cap_i) begin
        frame_q <= frame_nx;
        nbits_q <= (tot > NB_W'(FRAME_W)) ? NB_W'(FRAME_W) : tot;
        ovf_q   <= ovf_nx;
      end
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = err_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  err_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);

  // R8
  overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && done_i) |=> frame_err_o);

endmodule

// File: rtl/uart_ei_rx.sv
module uart_ei_rx #(
  parameter int unsigned BIT_W     = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);

  localparam int unsigned FRAME_W = DATA_BITS + 2;
  localparam int unsigned STOP_PT = (DATA_BITS + 1) * BIT_W + BIT_W / 2;
  localparam int unsigned CW      = $clog2(STOP_PT + 1);
  localparam int unsigned NB_W    = $clog2(2 * FRAME_W + 1);

  logic          lvl, edge_s, fall;
  logic          busy, cap, done, start;
  logic [CW-1:0] width;

  uart_ei_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .lvl_o  (lvl),
    .edge_o (edge_s),
    .fall_o (fall)
  );

  uart_ei_timer #(
    .STOP_PT (STOP_PT),
    .CW      (CW)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_s),
    .fall_i  (fall),
    .busy_o  (busy),
    .cap_o   (cap),
    .done_o  (done),
    .start_o (start),
    .width_o (width)
  );

  uart_ei_assemble #(
    .BIT_W     (BIT_W),
    .DATA_BITS (DATA_BITS),
    .FRAME_W   (FRAME_W),
    .NB_W      (NB_W),
    .CW        (CW)
  ) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .start_i     (start),
    .done_i      (done),
    .width_i     (width),
    .lvl_i       (lvl),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
  );

  // R5
  valid_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy));

endmodule

// File: tb/tb_uart_ei_rx.sv
module tb_uart_ei_rx;

  localparam int BIT_W = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, frame_err_o;

  int tests = 0;
  int fails = 0;

  logic [7:0] got_d [64];
  logic       got_e [64];
  int         got_n = 0;
  int         dbl = 0;
  logic       prev_v = 1'b0;

  always #5 clk = ~clk;

  uart_ei_rx #(.BIT_W(BIT_W), .DATA_BITS(8)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && got_n < 64) begin
        got_d[got_n] = data_o;
        got_e[got_n] = frame_err_o;
        got_n++;
      end
      if (valid_o && prev_v) dbl++;
      prev_v = valid_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop, input int stop_len,
                            input int jidx, input int jit);
    logic [9:0] f;
    f = {stop, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      int len;
      len = BIT_W;
      if (k == jidx) len += jit;
      if (k == jidx + 1) len -= jit;
      if (k == 9) len = stop_len;
      drive(f[k], len);
    end
  endtask

  task automatic check_one(input int n0, input logic [7:0] ed, input logic ee, input string req);
    chk(got_n == n0 + 1, {req, " strobe count"}, got_n - n0, 1);
    chk(got_d[n0] == ed, {req, " data"}, got_d[n0], ed);
    chk(got_e[n0] == ee, {req, " frame_err"}, got_e[n0], ee);
    chk(data_o == ed, "R6 data_o held", data_o, ed);
  endtask

  task automatic t_reset;
    chk(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    chk(frame_err_o == 1'b0, "R1 frame_err after reset", frame_err_o, 0);
    chk(data_o == 8'h00, "R1 data after reset", data_o, 0);
    drive(1'b1, 200);
    chk(got_n == 0, "R2 idle high gives no strobe", got_n, 0);
  endtask

  task automatic t_clean(input logic [7:0] d, input string req);
    int n0;
    n0 = got_n;
    send_frame(d, 1'b1, BIT_W, -1, 0);
    drive(1'b1, 3 * BIT_W);
    check_one(n0, d, 1'b0, req);
  endtask

  task automatic t_jitter(input logic [7:0] d, input int idx, input int jit);
    int n0;
    n0 = got_n;
    send_frame(d, 1'b1, BIT_W, idx, jit);
    drive(1'b1, 3 * BIT_W);
    check_one(n0, d, 1'b0, "R3 shifted edge");
  endtask

  task automatic t_stop_low;
    int n0;
    n0 = got_n;
    send_frame(8'h35, 1'b0, BIT_W, -1, 0);
    drive(1'b0, 3 * BIT_W);
    drive(1'b1, 3 * BIT_W);
    check_one(n0, 8'h35, 1'b1, "R7 low stop bit");
    chk(got_n == n0 + 1, "R10 rising edge in idle ignored", got_n - n0, 1);
    t_clean(8'hC3, "R10 recovery");
  endtask

  task automatic t_overflow;
    int n0;
    n0 = got_n;
    drive(1'b0, 16);
    drive(1'b1, 24);
    drive(1'b0, 24);
    drive(1'b1, 24);
    drive(1'b0, 24);
    drive(1'b1, 24);
    drive(1'b0, 40);
    drive(1'b1, 3 * BIT_W);
    check_one(n0, 8'h33, 1'b1, "R8 bit overflow");
  endtask

  task automatic t_coincide;
    int n0;
    n0 = got_n;
    send_frame(8'hFF, 1'b1, BIT_W / 2, -1, 0);
    send_frame(8'h5A, 1'b1, BIT_W, -1, 0);
    drive(1'b1, 3 * BIT_W);
    chk(got_n == n0 + 2, "R9 two strobes", got_n - n0, 2);
    chk(got_d[n0] == 8'hFF, "R9 first data", got_d[n0], 8'hFF);
    chk(got_e[n0] == 1'b0, "R9 first frame_err", got_e[n0], 0);
    chk(got_d[n0+1] == 8'h5A, "R9 second data", got_d[n0+1], 8'h5A);
    chk(got_e[n0+1] == 1'b0, "R9 second frame_err", got_e[n0+1], 0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements): got 0x%0h expected 0x%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(8'h55, "R3 alternating");
    t_clean(8'h00, "R3 long low run");
    t_clean(8'hFF, "R5 open high tail");
    t_clean(8'h80, "R5 fill after last edge");
    t_clean(8'h01, "R4 lsb first");
    t_clean(8'hA5, "R4 mixed");
    t_clean(8'h3C, "R3 paired runs");
    t_jitter(8'h55, 3, 7);
    t_jitter(8'h55, 5, -7);
    t_stop_low();
    t_overflow();
    t_coincide();
    chk(dbl == 0, "R6 single-cycle strobe", dbl, 0);
    summary();
    $finish;
  end

endmodule